// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. Software reaches it over a plain register bus: an address, a write strobe, write data and combinational read data. Each pin has three things. The first is a synchronized input sample. The second is an output data latch. The third is an output-enable bit that decides whether the pin is driven.

Every pin can request an interrupt in two ways, and each way has its own mask. A level request is computed live from the synchronized input and a per-pin polarity bit, so it follows the pin and stores nothing. An edge request is latched when the synchronized input makes the transition that the pin's edge polarity selects. Software clears it by writing one to that bit. All unmasked requests are ORed into one pending flag. That flag is visible in a top-level status word and passes to the registered interrupt output only when the top-level enable is set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every writable register reads 0, `pin_oe` and `pin_o` are 0 and `irq_o` is 0.
- R2: The word at 0x04 sets `pin_o` and the word at 0x08 sets `pin_oe`, bit per pin, where a 1 in 0x08 drives the pin. Both read back as written, and `pin_oe` changes only on a write to 0x08.
- R3: A read of 0x00 returns `pin_i` after a two-flop synchronizer. A change driven just after a rising edge is not visible after the next edge and is visible after the second edge.
- R4: A pin's level request is (synchronized input XOR bit of 0x10) AND bit of 0x14. A 0 polarity bit means active-high and a 1 means active-low. The request is not latched and drops as soon as the condition goes away.
- R5: The event register at 0x18 sets a pin's bit on a rising synchronized transition when that pin's bit in 0x24 is 0, and on a falling transition when it is 1. No other transition sets it. The bit is set whatever the event mask at 0x1C holds.
- R6: Writing 1 to a bit of 0x18 clears that event and writing 0 leaves it unchanged. When a new edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: The pending set is the level requests OR (events AND 0x1C).
- R8: Bit 0 of 0x120 reads 1 exactly when any pending bit is set, and writes to 0x120 are ignored. Bit 0 of 0x124 is the top-level interrupt enable.
- R9: `irq_o` is registered. It is high in the cycle after any pending bit is set while the enable at 0x124 is 1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| pin_i | input | N | Raw pin inputs |
| pin_o | output | N | Output data per pin |
| pin_oe | output | N | Output enable per pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a new edge arriving in the same clock as a write-one-to-clear of the same event bit. The bench times this from the point where it drives the pin. It counts two synchronizer edges, raises the clear write so that it lands on the third edge, when the edge detector fires, and then reads the event register back. The exact latency of the synchronizer is also checked: the data-in register is read after one edge and again after two. Events are also made to latch while masked, and the bench then confirms that enabling the mask alone raises the interrupt.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    // byte offsets seen by software; the decode depends on these values
    localparam int OFS_DIN      = 'h000;
    localparam int OFS_DOUT     = 'h004;
    localparam int OFS_OE       = 'h008;
    localparam int OFS_LVL_POL  = 'h010;
    localparam int OFS_LVL_MSK  = 'h014;
    localparam int OFS_EVT      = 'h018;
    localparam int OFS_EVT_MSK  = 'h01C;
    localparam int OFS_EDGE_POL = 'h024;
    // top-level region
    localparam int OFS_TOP_STAT = 'h120;
    localparam int OFS_TOP_MSK  = 'h124;

    // edge polarity encoding
    typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] stage;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = raw_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d.stage[k] = st_q.stage[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
`timescale 1ns/1ps
module gpio_edge_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] edge_pol_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] clr_bits_i,
    output logic [N-1:0] hit_o,
    output logic [N-1:0] evt_o
);
    import gpio_irq_pkg::*;

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] evt;
    } edge_t;

    edge_t st_d, st_q;
    logic [N-1:0] hit_w;
    logic [N-1:0] clr_w;

    for (genvar g = 0; g < N; g++) begin : g_pin
        always_comb begin
            if (edge_sel_e'(edge_pol_i[g]) == EDGE_FALL)
                hit_w[g] = st_q.prev[g] & ~sync_i[g];
            else
                hit_w[g] = ~st_q.prev[g] & sync_i[g];
        end
    end

    always_comb begin
        clr_w     = clr_en_i ? clr_bits_i : '0;
        st_d      = st_q;
        st_d.prev = sync_i;
        // a fresh edge wins over a clear of the same bit
        st_d.evt  = (st_q.evt & ~clr_w) | hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = hit_w;
    assign evt_o = st_q.evt;
endmodule

// File: rtl/gpio_reg_bank.sv
`timescale 1ns/1ps
module gpio_reg_bank #(
    parameter int N      = 32,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      din_i,
    input  logic [N-1:0]      evt_i,
    input  logic              top_stat_i,
    output logic [N-1:0]      dout_o,
    output logic [N-1:0]      oe_o,
    output logic [N-1:0]      lvl_pol_o,
    output logic [N-1:0]      lvl_msk_o,
    output logic [N-1:0]      evt_msk_o,
    output logic [N-1:0]      edge_pol_o,
    output logic              top_msk_o,
    output logic              evt_clr_o
);
    import gpio_irq_pkg::*;

    typedef struct packed {
        logic [N-1:0] dout;
        logic [N-1:0] oe;
        logic [N-1:0] lvl_pol;
        logic [N-1:0] lvl_msk;
        logic [N-1:0] evt_msk;
        logic [N-1:0] edge_pol;
        logic         top_msk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [N-1:0] wbits;

    assign wbits = bus_wdata[N-1:0];

    always_comb begin
        ctl_d = ctl_q;
        if (bus_we) begin
            case (bus_addr)
                ADDR_W'(OFS_DOUT):     ctl_d.dout     = wbits;
                ADDR_W'(OFS_OE):       ctl_d.oe       = wbits;
                ADDR_W'(OFS_LVL_POL):  ctl_d.lvl_pol  = wbits;
                ADDR_W'(OFS_LVL_MSK):  ctl_d.lvl_msk  = wbits;
                ADDR_W'(OFS_EVT_MSK):  ctl_d.evt_msk  = wbits;
                ADDR_W'(OFS_EDGE_POL): ctl_d.edge_pol = wbits;
                ADDR_W'(OFS_TOP_MSK):  ctl_d.top_msk  = bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_DIN):      bus_rdata = DATA_W'(din_i);
            ADDR_W'(OFS_DOUT):     bus_rdata = DATA_W'(ctl_q.dout);
            ADDR_W'(OFS_OE):       bus_rdata = DATA_W'(ctl_q.oe);
            ADDR_W'(OFS_LVL_POL):  bus_rdata = DATA_W'(ctl_q.lvl_pol);
            ADDR_W'(OFS_LVL_MSK):  bus_rdata = DATA_W'(ctl_q.lvl_msk);
            ADDR_W'(OFS_EVT):      bus_rdata = DATA_W'(evt_i);
            ADDR_W'(OFS_EVT_MSK):  bus_rdata = DATA_W'(ctl_q.evt_msk);
            ADDR_W'(OFS_EDGE_POL): bus_rdata = DATA_W'(ctl_q.edge_pol);
            ADDR_W'(OFS_TOP_STAT): bus_rdata = DATA_W'(top_stat_i);
            ADDR_W'(OFS_TOP_MSK):  bus_rdata = DATA_W'(ctl_q.top_msk);
            default:               bus_rdata = '0;
        endcase
    end

    assign dout_o     = ctl_q.dout;
    assign oe_o       = ctl_q.oe;
    assign lvl_pol_o  = ctl_q.lvl_pol;
    assign lvl_msk_o  = ctl_q.lvl_msk;
    assign evt_msk_o  = ctl_q.evt_msk;
    assign edge_pol_o = ctl_q.edge_pol;
    assign top_msk_o  = ctl_q.top_msk;
    assign evt_clr_o  = bus_we && (bus_addr == ADDR_W'(OFS_EVT));
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl #(
    parameter int N      = 32,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      pin_i,
    output logic [N-1:0]      pin_o,
    output logic [N-1:0]      pin_oe,
    output logic              irq_o
);
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic irq;
    } out_t;

    out_t out_d, out_q;

    logic [N-1:0] din_w, hit_w, evt_q;
    logic [N-1:0] lvl_pol, lvl_msk, evt_msk, edge_pol;
    logic [N-1:0] lvl_req, pend_w;
    logic         top_msk, evt_clr, any_pend;

    gpio_pin_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .sync_o (din_w)
    );

    gpio_edge_latch #(.N(N)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (din_w),
        .edge_pol_i (edge_pol),
        .clr_en_i   (evt_clr),
        .clr_bits_i (bus_wdata[N-1:0]),
        .hit_o      (hit_w),
        .evt_o      (evt_q)
    );

    gpio_reg_bank #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .din_i      (din_w),
        .evt_i      (evt_q),
        .top_stat_i (any_pend),
        .dout_o     (pin_o),
        .oe_o       (pin_oe),
        .lvl_pol_o  (lvl_pol),
        .lvl_msk_o  (lvl_msk),
        .evt_msk_o  (evt_msk),
        .edge_pol_o (edge_pol),
        .top_msk_o  (top_msk),
        .evt_clr_o  (evt_clr)
    );

    always_comb begin
        lvl_req   = (din_w ^ lvl_pol) & lvl_msk;
        pend_w    = lvl_req | (evt_q & evt_msk);
        any_pend  = |pend_w;
        out_d     = out_q;
        out_d.irq = any_pend & top_msk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o = out_q.irq;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk #(
    parameter int N      = 32,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N-1:0]      pin_oe,
    input logic              irq_o,
    input logic [N-1:0]      pend_w,
    input logic              top_msk,
    input logic [N-1:0]      hit_w,
    input logic [N-1:0]      evt_q
);
    import gpio_irq_pkg::*;

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pend_w) && top_msk) |=> irq_o);  // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !((|pend_w) && top_msk) |=> !irq_o);  // R9
    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_w) |=> ((evt_q & $past(hit_w)) == $past(hit_w)));  // R5
    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_EVT) && hit_w == '0)
        |=> ((evt_q & $past(bus_wdata[N-1:0])) == '0));  // R6
    AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_W'(OFS_OE)) |=> $stable(pin_oe));  // R2
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq_o     (irq_o),
    .pend_w    (pend_w),
    .top_msk   (top_msk),
    .hit_w     (hit_w),
    .evt_q     (evt_q)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
    localparam int N = 32;
    localparam int AW = 9;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pin_i = '0;
    logic [N-1:0]  pin_o, pin_oe;
    logic          irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // kinds: 0 read data, 1 irq, 2 pin_oe, 3 pin_o
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       rid;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.N(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
        .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step();
        bus_addr = AW'(a); bus_we = 1'b1; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic expect_item(input int kind, input int a, input logic [31:0] e, input string rid);
        item_t it;
        step();
        if (kind == 0) bus_addr = AW'(a);
        it.kind = kind; it.exp = e; it.rid = rid;
        sb_q.push_back(it);
    endtask

    // monitor: pops expectations and compares half a cycle later
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {31'b0, irq_o};
                    2: act = pin_oe;
                    default: act = pin_o;
                endcase
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.rid, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_item(0, 'h004, 0, "R1 dout");
        expect_item(0, 'h008, 0, "R1 oe");
        expect_item(0, 'h010, 0, "R1 lvl_pol");
        expect_item(0, 'h014, 0, "R1 lvl_msk");
        expect_item(0, 'h018, 0, "R1 evt");
        expect_item(0, 'h01C, 0, "R1 evt_msk");
        expect_item(0, 'h024, 0, "R1 edge_pol");
        expect_item(0, 'h124, 0, "R1 top_msk");
        expect_item(1, 0, 0, "R1 irq");
        expect_item(2, 0, 0, "R1 pin_oe");
        expect_item(3, 0, 0, "R1 pin_o");

        // R2 outputs
        wr('h004, 32'hA5A5_0F0F);
        wr('h008, 32'hFFFF_0000);
        expect_item(3, 0, 32'hA5A5_0F0F, "R2 pin_o");
        expect_item(2, 0, 32'hFFFF_0000, "R2 pin_oe");
        expect_item(0, 'h004, 32'hA5A5_0F0F, "R2 dout readback");
        expect_item(0, 'h008, 32'hFFFF_0000, "R2 oe readback");

        // R3 two-flop latency
        pin_i = 32'h0000_00F0;
        expect_item(0, 'h000, 0, "R3 din after one edge");
        expect_item(0, 'h000, 32'h0000_00F0, "R3 din after two edges");

        // R4 level, active-high then active-low
        wr('h124, 1);
        wr('h014, 32'h10);
        wait_n(3);
        expect_item(1, 0, 1, "R4 level high irq");
        expect_item(0, 'h120, 1, "R8 status set");
        wr('h010, 32'h10);
        wait_n(2);
        expect_item(1, 0, 0, "R4 active-low with pin high");
        pin_i = 32'h0;
        wait_n(4);
        expect_item(1, 0, 1, "R4 active-low with pin low");
        pin_i = 32'h10;
        wait_n(4);
        expect_item(1, 0, 0, "R4 not latched");
        wr('h014, 0);
        wr('h010, 0);
        pin_i = 32'h0;
        wait_n(4);
        wr('h018, 32'hFFFF_FFFF);
        expect_item(0, 'h018, 0, "R6 clear all");
        expect_item(1, 0, 0, "R7 nothing pending");

        // R5 rising edge latches while masked
        pin_i = 32'h2;
        wait_n(4);
        expect_item(0, 'h018, 32'h2, "R5 rise latched masked");
        expect_item(1, 0, 0, "R5 masked no irq");
        wr('h01C, 32'h2);
        wait_n(1);
        expect_item(1, 0, 1, "R7 unmasked event raises irq");
        wr('h018, 32'h0);
        expect_item(0, 'h018, 32'h2, "R6 write zero keeps");
        wr('h018, 32'h2);
        expect_item(0, 'h018, 0, "R6 write one clears");
        wait_n(1);
        expect_item(1, 0, 0, "R9 irq drops after clear");

        // R5 falling selection
        wr('h024, 32'h4);
        pin_i = 32'h6;
        wait_n(4);
        expect_item(0, 'h018, 0, "R5 falling-mode ignores rise");
        pin_i = 32'h2;
        wait_n(4);
        expect_item(0, 'h018, 32'h4, "R5 falling latched");

        // R8 top-level gating
        wr('h01C, 32'h4);
        wait_n(1);
        expect_item(1, 0, 1, "R8 enabled irq");
        wr('h124, 0);
        wait_n(1);
        expect_item(1, 0, 0, "R8 top mask blocks");
        expect_item(0, 'h120, 1, "R8 status unmasked");
        wr('h120, 0);
        expect_item(0, 'h120, 1, "R8 status write ignored");
        wr('h124, 1);
        wait_n(1);
        expect_item(1, 0, 1, "R9 re-enabled");
        wr('h018, 32'h4);
        wait_n(1);
        expect_item(1, 0, 0, "R9 cleared");
        expect_item(0, 'h120, 0, "R8 status clear");

        // R6 set wins over same-cycle clear (pin3, rising)
        pin_i = 32'hA;
        step(); step();
        bus_addr = AW'('h018); bus_we = 1'b1; bus_wdata = 32'h8;
        step();
        bus_we = 1'b0;
        expect_item(0, 'h018, 32'h8, "R6 set wins");

        wait_n(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule